// File: doc/BRIEF.md
# Tributary Alarm and Frame Status Register

This block is a 16-bit status word that a host reads over a simple strobe bus. It collects remote-alarm indications from up to seven tributary framers and frame-boundary information from four of them. Each alarm channel has a sticky status bit that is set while the alarm is present. That bit is cleared by a host read only once the alarm has gone away.

Every alarm input also feeds a change detector that fires on a rising or a falling edge. The per-channel change latches are ORed together and gated by a local enable bit to form a master status output. A second, external mask then gates the master status onto an active-low interrupt line. A read of the word clears every change latch, which releases the interrupt.

The upper byte carries four national-bit values, each refreshed at its channel's frame start, and four sticky start-of-frame flags. None of these can raise the interrupt. In the alternate line mode, only the first four alarm channels are meaningful. The upper three alarm channels are then held at zero and kept out of the interrupt.

Top module: `trib_alarm_stat`

## Requirements
- R1: Bit i (i = 0..6) of `rd_data` is the alarm latch of channel i+1. It reads 1 from the clock edge after its `alarm_in[i]` is sampled high.
- R2: A read (`rd_stb` high at a clock edge) clears an alarm latch only if that channel's alarm is low at that same edge. An alarm that is high at the read edge leaves the bit set.
- R3: Every rising or falling change of an enabled channel's `alarm_in` bit, relative to its value at the previous edge, sets that channel's change latch. `mstr_stat` is high while bit 7 is 1 and any change latch is set.
- R4: Bit 7 of `rd_data` is the interrupt enable and is loaded from `wr_data[7]` when `wr_stb` is high. All other written bits are ignored. With the enable at 0, no change reaches `mstr_stat`.
- R5: `irq_n` is low exactly when `mstr_stat` is high and `mstr_mask` is high.
- R6: A read clears all change latches, so `mstr_stat` is low after the read edge unless a new change is sampled at that same edge.
- R7: Bits 8..11 hold the national bits of channels 1..4. Each bit loads `nat_bit_in[k]` at an edge where `sof_in[k]` is high and holds its value otherwise. It never affects `mstr_stat`.
- R8: Bits 12..15 are start-of-frame latches for channels 1..4. A latch sets at the edge after `sof_in[k]` is high and clears on read. A frame start sampled at the read edge wins over the clear. These latches never affect `mstr_stat`.
- R9: While `alt_mode` is high, bits 4..6 (channels 5..7) read 0, and those channels produce no change events.
- R10: After reset, `rd_data` is 0, `mstr_stat` is 0 and `irq_n` is 1.
- R11: `rd_data` shows the state before a read takes effect. The clear becomes visible only after the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_stb | input | 1 | Host read strobe; clears latches at the clock edge |
| wr_stb | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write data (only bit 7 used) |
| rd_data | output | 16 | Current register value |
| alt_mode | input | 1 | Alternate line mode; disables alarm channels 5..7 |
| alarm_in | input | 7 | Per-channel remote-alarm indication |
| nat_bit_in | input | 4 | Per-channel decoded national bit |
| sof_in | input | 4 | Per-channel frame start pulse |
| mstr_mask | input | 1 | Master interrupt mask bit, 1 = pass |
| mstr_stat | output | 1 | Master status: enabled alarm change pending |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The assertions check several behaviours on every cycle:
- an alarm that is present forces its latch;
- a read with the alarm absent clears the latch;
- change latches hold until a read;
- a read with no new change drops `mstr_stat`;
- a frame start sets its flag and national bits move only on a frame start;
- the external mask holds `irq_n` high;
- the gated channels read zero in alternate mode.

Some behaviours only the bench scenarios can show. These are that falling edges as well as rising ones raise the interrupt, that a disabled enable suppresses it, and that written bits other than the enable change nothing. The bench also shows that the read value is the pre-clear state, that events arriving in the read cycle survive, and that leaving alternate mode with an alarm still high latches the alarm without raising the interrupt.

// File: rtl/trib_alarm_pkg.sv
package trib_alarm_pkg;
   localparam int DEF_N_ALM    = 7;
   localparam int DEF_N_SUB    = 4;
   localparam int DEF_ALT_KEEP = 4;

   // bits of the alarm field that alternate mode forces to zero
   function automatic logic [31:0] gated_mask(input int n_alm, input int keep);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < n_alm; i++) begin
         if (i >= keep) m[i] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/alarm_chan.sv
module alarm_chan (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_clr,
   input  logic chan_en,
   input  logic alarm_in,
   output logic stat_q,
   output logic evt_q,
   output logic chg
);
   logic prev_q;
   logic live;

   assign live = chan_en & alarm_in;
   assign chg  = chan_en & (alarm_in ^ prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         stat_q <= 1'b0;
         evt_q  <= 1'b0;
      end else begin
         prev_q <= alarm_in;
         if (!chan_en) begin
            stat_q <= 1'b0;
            evt_q  <= 1'b0;
         end else if (rd_clr) begin
            stat_q <= live;
            evt_q  <= chg;
         end else begin
            stat_q <= stat_q | live;
            evt_q  <= evt_q | chg;
         end
      end
   end

   a_r1_alarm_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && alarm_in) |=> stat_q);
   a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !alarm_in) |=> !stat_q);
   a_r3_event_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_q && !rd_clr && chan_en) |=> evt_q);
endmodule

// File: rtl/frame_chan.sv
module frame_chan (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_clr,
   input  logic sof_pulse,
   input  logic nat_in,
   output logic nat_q,
   output logic sof_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nat_q <= 1'b0;
         sof_q <= 1'b0;
      end else begin
         if (sof_pulse) nat_q <= nat_in;
         sof_q <= rd_clr ? sof_pulse : (sof_q | sof_pulse);
      end
   end

   a_r8_sof_sets: assert property (@(posedge clk) disable iff (!rst_n)
      sof_pulse |=> sof_q);
   a_r7_nat_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !sof_pulse |=> $stable(nat_q));
endmodule

// File: rtl/irq_stage.sv
module irq_stage #(
   parameter int N_EVT = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt_vec,
   input  logic             ien,
   input  logic             mstr_mask,
   output logic             mstr_stat,
   output logic             irq_n
);
   logic any_evt;

   assign any_evt   = |evt_vec;
   assign mstr_stat = ien & any_evt;
   assign irq_n     = ~(mstr_stat & mstr_mask);

   a_r5_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      !mstr_mask |-> irq_n);
   a_r4_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
      !ien |-> !mstr_stat);
endmodule

// File: rtl/trib_alarm_stat.sv
module trib_alarm_stat
   import trib_alarm_pkg::*;
#(
   parameter int N_ALM    = DEF_N_ALM,
   parameter int N_SUB    = DEF_N_SUB,
   parameter int ALT_KEEP = DEF_ALT_KEEP,
   parameter int DATA_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              alt_mode,
   input  logic [N_ALM-1:0]  alarm_in,
   input  logic [N_SUB-1:0]  nat_bit_in,
   input  logic [N_SUB-1:0]  sof_in,
   input  logic              mstr_mask,
   output logic              mstr_stat,
   output logic              irq_n
);
   localparam int          IEN_POS   = N_ALM;
   localparam logic [31:0] GATE_FULL = gated_mask(N_ALM, ALT_KEEP);
   localparam logic [N_ALM-1:0] GATE_MASK = GATE_FULL[N_ALM-1:0];

   if (DATA_W != N_ALM + 1 + 2 * N_SUB) begin : g_bad_width
      $error("trib_alarm_stat: DATA_W must equal N_ALM + 1 + 2*N_SUB");
   end
   if (ALT_KEEP > N_ALM || N_SUB > N_ALM) begin : g_bad_count
      $error("trib_alarm_stat: channel counts out of range");
   end

   logic [N_ALM-1:0] chan_en;
   logic [N_ALM-1:0] alm_stat;
   logic [N_ALM-1:0] alm_evt;
   logic [N_ALM-1:0] alm_chg;
   logic [N_SUB-1:0] nat_q;
   logic [N_SUB-1:0] sof_q;
   logic             ien_q;
   logic             unused_wr;

   assign unused_wr = ^{wr_data[DATA_W-1:IEN_POS+1], wr_data[IEN_POS-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ien_q <= 1'b0;
      else if (wr_stb) ien_q <= wr_data[IEN_POS];
   end

   for (genvar i = 0; i < N_ALM; i++) begin : g_alm
      if (i >= ALT_KEEP) begin : g_gated
         assign chan_en[i] = ~alt_mode;
      end else begin : g_always
         assign chan_en[i] = 1'b1;
      end
      alarm_chan u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .rd_clr   (rd_stb),
         .chan_en  (chan_en[i]),
         .alarm_in (alarm_in[i]),
         .stat_q   (alm_stat[i]),
         .evt_q    (alm_evt[i]),
         .chg      (alm_chg[i])
      );
   end

   for (genvar k = 0; k < N_SUB; k++) begin : g_frm
      frame_chan u_frm (
         .clk       (clk),
         .rst_n     (rst_n),
         .rd_clr    (rd_stb),
         .sof_pulse (sof_in[k]),
         .nat_in    (nat_bit_in[k]),
         .nat_q     (nat_q[k]),
         .sof_q     (sof_q[k])
      );
   end

   irq_stage #(.N_EVT(N_ALM)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_vec   (alm_evt),
      .ien       (ien_q),
      .mstr_mask (mstr_mask),
      .mstr_stat (mstr_stat),
      .irq_n     (irq_n)
   );

   assign rd_data = {sof_q, nat_q, ien_q, alm_stat};

   a_r6_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !(|alm_chg)) |=> !mstr_stat);
   a_r9_alt_zero: assert property (@(posedge clk) disable iff (!rst_n)
      alt_mode |=> ((alm_stat & GATE_MASK) == '0));
endmodule

// File: tb/tb_trib_alarm_stat.sv
module tb_trib_alarm_stat;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_stb = 1'b0;
   logic        wr_stb = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        alt_mode = 1'b0;
   logic [6:0]  alarm_in = '0;
   logic [3:0]  nat_bit_in = '0;
   logic [3:0]  sof_in = '0;
   logic        mstr_mask = 1'b0;
   logic        mstr_stat;
   logic        irq_n;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   typedef struct { logic [15:0] val; string tag; } exp_t;
   exp_t exp_q[$];

   always #5 clk = ~clk;

   trib_alarm_stat dut (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
      .wr_data(wr_data), .rd_data(rd_data), .alt_mode(alt_mode),
      .alarm_in(alarm_in), .nat_bit_in(nat_bit_in), .sof_in(sof_in),
      .mstr_mask(mstr_mask), .mstr_stat(mstr_stat), .irq_n(irq_n)
   );

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: issue a read and queue the value it should return
   task automatic rd(input logic [15:0] exp, input string tag);
      exp_t e;
      e.val = exp;
      e.tag = tag;
      exp_q.push_back(e);
      rd_stb = 1'b1;
      step();
      rd_stb = 1'b0;
   endtask

   task automatic wr(input logic [15:0] v);
      wr_data = v;
      wr_stb  = 1'b1;
      step();
      wr_stb  = 1'b0;
   endtask

   // monitor: compare each read value against the queue head
   always @(negedge clk) begin
      #3;
      if (rd_stb) begin
         if (exp_q.size() == 0) begin
            chk("unexpected read", rd_data, 16'hxxxx);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.tag, rd_data, e.val);
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   initial begin
      #2000000;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      chk("R10 reset rd_data", rd_data, 16'h0000);
      chk("R10 reset mstr_stat", {15'b0, mstr_stat}, 16'h0);
      chk("R10 reset irq_n", {15'b0, irq_n}, 16'h1);

      mstr_mask = 1'b1;
      wr(16'h0080);
      // rising alarm on channel 1
      alarm_in[0] = 1'b1;
      step();
      chk("R3 rise sets mstr_stat", {15'b0, mstr_stat}, 16'h1);
      chk("R5 irq_n low", {15'b0, irq_n}, 16'h0);
      rd(16'h0081, "R1 R11 alarm read");
      chk("R6 read releases mstr_stat", {15'b0, mstr_stat}, 16'h0);
      chk("R6 read releases irq_n", {15'b0, irq_n}, 16'h1);
      rd(16'h0081, "R2 alarm still present stays");

      // falling edge also an event
      alarm_in[0] = 1'b0;
      step();
      chk("R3 fall sets mstr_stat", {15'b0, mstr_stat}, 16'h1);
      rd(16'h0081, "R2 latch held until read");
      rd(16'h0080, "R2 cleared once alarm gone");

      // one-cycle pulse on channel 3
      alarm_in[2] = 1'b1;
      step();
      alarm_in[2] = 1'b0;
      step();
      chk("R3 pulse mstr_stat", {15'b0, mstr_stat}, 16'h1);
      rd(16'h0084, "R1 pulse latched");
      rd(16'h0080, "R2 pulse cleared");

      // external mask
      mstr_mask = 1'b0;
      alarm_in[1] = 1'b1;
      step();
      chk("R5 masked mstr_stat", {15'b0, mstr_stat}, 16'h1);
      chk("R5 masked irq_n", {15'b0, irq_n}, 16'h1);
      mstr_mask = 1'b1;
      step();
      chk("R5 unmasked irq_n", {15'b0, irq_n}, 16'h0);
      rd(16'h0082, "R1 channel 2");
      chk("R6 cleared", {15'b0, mstr_stat}, 16'h0);

      // enable off; other written bits ignored
      wr(16'hFF7F);
      alarm_in[1] = 1'b0;
      step();
      chk("R4 disabled mstr_stat", {15'b0, mstr_stat}, 16'h0);
      chk("R4 disabled irq_n", {15'b0, irq_n}, 16'h1);
      rd(16'h0002, "R4 write ignored except bit7");
      rd(16'h0000, "R2 clear");
      wr(16'h0080);
      chk("R4 enable readback", rd_data, 16'h0080);

      // alternate mode
      alt_mode = 1'b1;
      alarm_in[5] = 1'b1;
      step();
      chk("R9 gated no event", {15'b0, mstr_stat}, 16'h0);
      rd(16'h0080, "R9 gated bit reads zero");
      alt_mode = 1'b0;
      step();
      chk("R9 no event on mode exit", {15'b0, mstr_stat}, 16'h0);
      rd(16'h00A0, "R1 channel 6 latched after mode exit");
      alarm_in[5] = 1'b0;
      step();
      chk("R3 channel 6 fall", {15'b0, mstr_stat}, 16'h1);
      rd(16'h00A0, "R2 held");
      rd(16'h0080, "R2 cleared");

      // alarm arriving in the read cycle
      alarm_in[3] = 1'b1;
      rd(16'h0080, "R11 pre-clear value");
      chk("R6 event at read edge kept", {15'b0, mstr_stat}, 16'h1);
      rd(16'h0088, "R2 alarm at read edge kept");
      alarm_in[3] = 1'b0;
      step();
      rd(16'h0088, "R2 held");
      rd(16'h0080, "R2 cleared");

      // national bits and frame starts
      nat_bit_in = 4'b1010;
      sof_in     = 4'b0011;
      step();
      sof_in     = 4'b0000;
      nat_bit_in = 4'b0101;
      step();
      chk("R7 R8 no interrupt", {15'b0, mstr_stat}, 16'h0);
      rd(16'h3280, "R7 R8 loaded");
      rd(16'h0280, "R8 cleared R7 held");
      nat_bit_in = 4'b0100;
      sof_in     = 4'b0100;
      step();
      sof_in     = 4'b0000;
      sof_in     = 4'b1000;
      rd(16'h4680, "R7 R8 channel 3 frame");
      sof_in     = 4'b0000;
      rd(16'h8680, "R8 frame start at read edge kept");
      rd(16'h0680, "R8 cleared");
      chk("R8 no interrupt", {15'b0, irq_n}, 16'h1);

      step();
      chk("scoreboard drained", 16'(exp_q.size()), 16'h0);
      finish_run();
   end
endmodule